// File: doc/BRIEF.md
# External Bus Area Controller

This block connects one internal request port to an external asynchronous memory bus. The 24-bit address space is split into eight equal areas. Each area owns an active-low chip select and a private timing setup. When a request arrives, the controller picks the area from the top address bits and holds that area's chip select low for the whole access. It then runs one or two byte-lane bus cycles, drives the read or write strobes, and returns the read data together with a one-cycle acknowledge.

Every area can be set up on its own. The options are an 8-bit or 16-bit data path, a fast 2-state or a slower 3-state cycle, 0 to 7 programmed wait cycles, and waits stretched by an external wait input. An area can also add one cycle of chip-select lead before the strobes and one cycle of chip-select trail after them. Finally, it can hold the read strobe low for an extra half clock after the data has been captured, which suits devices with long output hold times. Area setups are loaded through a small register write port.

Top module: `ext_bus_ctrl`

## Requirements
- R1: An access to address A asserts only cs_n[A[23:21]] low, in every cycle from the first state to the last extension cycle, and all chip selects are high whenever no access is running (including after reset).
- R2: The area setup word is 9 bits: [2:0] programmed wait count, [3] 16-bit width, [4] 3-state cycle, [5] wait input enable, [6] lead extension, [7] trail extension, [8] late read-strobe release. A write with cfg_we high loads the area addressed by cfg_idx. All setups reset to zero, which means an 8-bit, 2-state area with no extras.
- R3: A 2-state area takes exactly 2 cycles per byte cycle. It ignores both its programmed wait count and the wait input.
- R4: A 3-state area takes 3 plus its programmed wait count of cycles per byte cycle, when no pin waits are added.
- R5: In a 3-state area with the wait enable set, ext_wait is sampled on the falling clock edge. Once the programmed waits are used up, each high sample adds one more wait cycle before the final state. With the enable clear, ext_wait has no effect.
- R6: The lead extension adds one cycle in which the chip select is low and the strobes are high before the strobes start. The trail extension adds one such cycle after the final state. Each applies to every byte cycle.
- R7: A 16-bit area carries even addresses on bus_din/bus_dout[15:8] and odd addresses on [7:0]. A word access is one cycle at the even address with both write strobes. A byte write pulses only wrh_n (even address) or only wrl_n (odd address).
- R8: An 8-bit area uses only the lower lane and never pulses wrh_n. A word access there becomes two byte cycles: first the even address carrying bits [15:8], then the odd address carrying bits [7:0].
- R9: With late release set, rd_n stays low for half a clock after the edge that ends the final state. The read data is still taken at that edge.
- R10: ack is a one-cycle pulse. It is high in the cycle after the last state of the whole access, so its latency from the accepting edge equals the total number of states. rdata is valid while ack is high, and byte reads return zero in rdata[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Area setup write strobe |
| cfg_idx | input | 3 | Area number written |
| cfg_wdata | input | 9 | Area setup word |
| req | input | 1 | Access request, held until ack |
| req_addr | input | 24 | Byte address |
| req_we | input | 1 | 1 for write |
| req_word | input | 1 | 1 for 16-bit access (address bit 0 ignored) |
| req_wdata | input | 16 | Write data (byte access uses [7:0]) |
| ack | output | 1 | Access finished |
| rdata | output | 16 | Read data |
| ext_wait | input | 1 | External wait request, active high |
| bus_addr | output | 24 | External address |
| bus_dout | output | 16 | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 16 | External read data |
| cs_n | output | 8 | Area chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wrh_n | output | 1 | Upper lane write strobe, active low |
| wrl_n | output | 1 | Lower lane write strobe, active low |

## Verification
The assertions take three things for granted about the inputs. First, req stays high with stable address, direction, size and data until ack. Second, no area setup is written while an access is in flight. Third, word requests name an aligned pair. The stimulus meets these conditions by construction. Each access is driven from a task that raises req at a falling edge, holds every field until it sees ack, and drops req after one idle cycle; setup writes happen only between accesses. The wait input is raised at request time and dropped after a chosen number of cycles, so the expected stretch can be computed from the cycle count alone.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int CFG_W = 9;

  typedef struct packed {
    logic       rd_late;
    logic       ext_post;
    logic       ext_pre;
    logic       wait_en;
    logic       three;
    logic       wide;
    logic [2:0] waits;
  } area_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_T1, S_T2, S_TW, S_T3, S_POST, S_ACK
  } bus_st_t;

  // Which byte lanes a cycle touches: [1] upper (even), [0] lower (odd)
  function automatic logic [1:0] lane_mask(logic wide, logic word, logic a0);
    if (!wide)      return 2'b01;
    else if (word)  return 2'b11;
    else            return a0 ? 2'b01 : 2'b10;
  endfunction

  // Start state of a byte cycle
  function automatic bus_st_t first_state(area_cfg_t c);
    return c.ext_pre ? S_PRE : S_T1;
  endfunction
endpackage

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
  import ebc_pkg::*;
#(
  parameter int N_AREAS = 8,
  localparam int AREA_W = $clog2(N_AREAS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AREA_W-1:0] idx,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [AREA_W-1:0] sel,
  output area_cfg_t         sel_cfg
);
  area_cfg_t bank [N_AREAS];

  for (genvar g = 0; g < N_AREAS; g++) begin : g_area
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bank[g] <= '0;
      else if (we && idx == AREA_W'(g))    bank[g] <= area_cfg_t'(wdata);
    end
  end

  assign sel_cfg = bank[sel];
endmodule

// File: rtl/ebc_area_dec.sv
module ebc_area_dec #(
  parameter int N_AREAS = 8,
  localparam int AREA_W = $clog2(N_AREAS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [AREA_W-1:0]  area,
  output logic [N_AREAS-1:0] cs_n
);
  for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
    assign cs_n[g] = !(active && area == AREA_W'(g));
  end

  // R1: never more than one area selected
  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R1: chip selects idle high while no access runs
  a_r1_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&cs_n));
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [15:0]       req_wdata,
  input  area_cfg_t         req_cfg,
  input  logic              ext_wait,
  input  logic [15:0]       bus_din,
  output logic              ack,
  output logic [15:0]       rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_dout,
  output logic              bus_oe,
  output logic              rd_n,
  output logic              wrh_n,
  output logic              wrl_n,
  output logic              cs_act
);
  bus_st_t           st_q, st_d;
  area_cfg_t         cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, word_q, ph_q;
  logic [15:0]       wd_q, rd_q;
  logic [2:0]        left_q;
  logic              wait_s, rd_hold;

  // Named internal events
  logic start, fin_st, in_wait_slot, prog_wait, pin_wait, more_ph, leave_ph;
  logic rd_act, wr_act;
  logic [1:0] lanes;
  logic [7:0] wr_byte;
  bus_st_t    next_ph;

  assign start        = (st_q == S_IDLE) && req;
  assign fin_st       = (st_q == S_T3) || (st_q == S_T2 && !cfg_q.three);
  assign in_wait_slot = (st_q == S_T2 || st_q == S_TW) && cfg_q.three;
  assign prog_wait    = in_wait_slot && (left_q != 3'd0);
  assign pin_wait     = in_wait_slot && (left_q == 3'd0) && cfg_q.wait_en && wait_s;
  assign more_ph      = word_q && !cfg_q.wide && !ph_q;
  assign leave_ph     = (fin_st && !cfg_q.ext_post) || (st_q == S_POST);
  assign next_ph      = more_ph ? first_state(cfg_q) : S_ACK;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (req) st_d = first_state(req_cfg);
      S_PRE:  st_d = S_T1;
      S_T1:   st_d = S_T2;
      S_T2, S_TW, S_T3: begin
        if (prog_wait || pin_wait) st_d = S_TW;
        else if (in_wait_slot)     st_d = S_T3;
        else                       st_d = cfg_q.ext_post ? S_POST : next_ph;
      end
      S_POST: st_d = next_ph;
      S_ACK:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cfg_q <= '0; addr_q <= '0; we_q <= 1'b0;
      word_q <= 1'b0; ph_q <= 1'b0; wd_q <= '0; rd_q <= '0; left_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        cfg_q <= req_cfg; addr_q <= req_addr; we_q <= req_we;
        word_q <= req_word; wd_q <= req_wdata; ph_q <= 1'b0; rd_q <= '0;
      end
      if (st_q == S_T1)   left_q <= cfg_q.waits;
      else if (prog_wait) left_q <= left_q - 3'd1;
      if (leave_ph && more_ph) ph_q <= 1'b1;
      if (fin_st && !we_q) begin
        if (cfg_q.wide)  rd_q <= word_q ? bus_din
                                        : {8'h00, addr_q[0] ? bus_din[7:0] : bus_din[15:8]};
        else if (!word_q) rd_q[7:0]  <= bus_din[7:0];
        else if (!ph_q)   rd_q[15:8] <= bus_din[7:0];
        else              rd_q[7:0]  <= bus_din[7:0];
      end
    end
  end

  // Falling-edge samplers: wait input and late read-strobe hold
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_s  <= 1'b0;
      rd_hold <= 1'b0;
    end else begin
      wait_s  <= ext_wait;
      rd_hold <= rd_act && cfg_q.rd_late;
    end
  end

  assign rd_act  = !we_q && (st_q inside {S_T1, S_T2, S_TW, S_T3});
  assign wr_act  =  we_q && (st_q inside {S_T2, S_TW, S_T3});
  assign lanes   = lane_mask(cfg_q.wide, word_q, addr_q[0]);
  assign wr_byte = (word_q && ph_q) ? wd_q[7:0] : (word_q ? wd_q[15:8] : wd_q[7:0]);

  assign cs_act   = (st_q != S_IDLE) && (st_q != S_ACK);
  assign ack      = (st_q == S_ACK);
  assign rdata    = rd_q;
  assign rd_n     = !(rd_act || rd_hold);
  assign wrh_n    = !(wr_act && lanes[1]);
  assign wrl_n    = !(wr_act && lanes[0]);
  assign bus_oe   = we_q && cs_act;
  assign bus_dout = (word_q && cfg_q.wide) ? wd_q : {wr_byte, wr_byte};
  assign bus_addr = !word_q    ? addr_q
                  : cfg_q.wide ? {addr_q[ADDR_W-1:1], 1'b0}
                               : {addr_q[ADDR_W-1:1], ph_q};

  // R10: acknowledge lasts a single cycle
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R3: a 2-state final state is never followed by wait or third state
  a_r3_two_state_short: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T2 && !cfg_q.three) |=> !(st_q inside {S_TW, S_T3}));
  // R5: the third state is reached only once no wait reason remains
  a_r5_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T3 && $past(st_q) != S_T3)
      |-> ($past(left_q) == 3'd0 && !($past(cfg_q.wait_en) && $past(wait_s))));
  // R8: an 8-bit area never strobes the upper lane
  a_r8_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cfg_q.wide) |-> wrh_n);
  // R7: write strobes only inside a selected access, never with read
  a_r7_wr_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrh_n || !wrl_n) |-> (cs_act && rd_n));
  // R6: lead and trail extension cycles keep strobes inactive
  a_r6_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PRE || st_q == S_POST) |-> (wrh_n && wrl_n && cs_act));
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int N_AREAS = 8,
  localparam int AREA_W = $clog2(N_AREAS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AREA_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               req,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_we,
  input  logic               req_word,
  input  logic [15:0]        req_wdata,
  output logic               ack,
  output logic [15:0]        rdata,
  input  logic               ext_wait,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [15:0]        bus_dout,
  output logic               bus_oe,
  input  logic [15:0]        bus_din,
  output logic [N_AREAS-1:0] cs_n,
  output logic               rd_n,
  output logic               wrh_n,
  output logic               wrl_n
);
  area_cfg_t req_cfg;
  logic      cs_act;

  ebc_cfg_regs #(.N_AREAS(N_AREAS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .sel(req_addr[ADDR_W-1 -: AREA_W]), .sel_cfg(req_cfg)
  );

  ebc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_we(req_we),
    .req_word(req_word), .req_wdata(req_wdata), .req_cfg(req_cfg),
    .ext_wait(ext_wait), .bus_din(bus_din), .ack(ack), .rdata(rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe), .rd_n(rd_n),
    .wrh_n(wrh_n), .wrl_n(wrl_n), .cs_act(cs_act)
  );

  ebc_area_dec #(.N_AREAS(N_AREAS)) u_dec (
    .clk(clk), .rst_n(rst_n), .active(cs_act),
    .area(bus_addr[ADDR_W-1 -: AREA_W]), .cs_n(cs_n)
  );
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, req, req_we, req_word, ack, ext_wait, bus_oe, rd_n, wrh_n, wrl_n;
  logic [2:0]  cfg_idx;
  logic [8:0]  cfg_wdata;
  logic [23:0] req_addr, bus_addr;
  logic [15:0] req_wdata, rdata, bus_dout, bus_din;
  logic [7:0]  cs_n;

  ext_bus_ctrl u_ext_bus_ctrl (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [8:0] bcfg [8];

  function automatic logic [7:0] dev_byte(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // External device model
  always_comb begin
    if (bcfg[bus_addr[23:21]][3])
      bus_din = {dev_byte({bus_addr[23:1], 1'b0}), dev_byte({bus_addr[23:1], 1'b1})};
    else
      bus_din = {8'hEE, dev_byte(bus_addr)};
  end

  // Write strobe log
  int nev = 0;
  logic [1:0]  ev_m [4];
  logic [23:0] ev_a [4];
  logic [15:0] ev_d [4];
  logic wr_idle = 1'b1;
  always @(negedge clk) begin
    if ((!wrh_n || !wrl_n) && wr_idle) begin
      if (nev < 4) begin
        ev_m[nev] = {!wrh_n, !wrl_n}; ev_a[nev] = bus_addr; ev_d[nev] = bus_dout;
      end
      nev++;
    end
    wr_idle = wrh_n && wrl_n;
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Total states of an access: pins waits come from samples c < d
  function automatic int exp_len(logic [8:0] c, bit word, int d);
    int s = 0;
    int nph = (word && !c[3]) ? 2 : 1;
    for (int p = 0; p < nph; p++) begin
      int c0  = s + int'(c[6]) + 2 + int'(c[2:0]);
      int pin = (c[4] && c[5] && d > c0) ? d - c0 : 0;
      s += int'(c[6]) + (c[4] ? 3 + int'(c[2:0]) + pin : 2) + int'(c[7]);
    end
    return s;
  endfunction

  task automatic set_cfg(int idx, logic [8:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = v; bcfg[idx] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic [23:0] a, bit we, bit word, logic [15:0] wd, int d);
    logic [2:0]  area = a[23:21];
    logic [8:0]  c = bcfg[area];
    int          exp = exp_len(c, word, d);
    int          cnt = 0, cs_good = 0, cs_bad = 0;
    logic        first_rd = 1'b1, ack_rd = 1'b1, rdm;
    bit          done = 0;
    logic [15:0] erd;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_we = we; req_word = word; req_wdata = wd;
    ext_wait = (d > 0); nev = 0;
    while (!done) begin
      @(posedge clk); cnt++;
      #1; if (cnt == d) ext_wait = 1'b0;
      #4;
      if (cnt == 1) first_rd = rd_n;
      if (cs_n == ~(8'b1 << area)) cs_good++;
      else if (cs_n != 8'hFF) cs_bad++;
      rdm = rd_n;
      @(negedge clk);
      if (ack) begin done = 1; ack_rd = rdm; end
      else if (cnt > 300) begin chk(0, "R10 access hung", cnt, exp); done = 1; end
    end
    req = 1'b0; ext_wait = 1'b0;
    chk(cnt == exp + 1, "R10 latency (R3 R4 R5 R6 timing)", cnt, exp + 1);
    chk(cs_good == exp && cs_bad == 0, "R1 chip select span", cs_good, exp);
    if (!we) begin
      erd = word ? {dev_byte({a[23:1], 1'b0}), dev_byte({a[23:1], 1'b1})}
                 : {8'h00, dev_byte(a)};
      chk(rdata == erd, "R7 R8 read data", rdata, erd);
      chk(first_rd == c[6], "R6 strobe during lead extension", first_rd, c[6]);
      chk(ack_rd == !(c[8] && !c[7]), "R9 read strobe release", ack_rd, !(c[8] && !c[7]));
    end else begin
      logic [1:0]  em [2];
      logic [23:0] ea [2];
      logic [15:0] ed [2];
      int ne = 1;
      if (c[3] && word) begin em[0] = 2'b11; ea[0] = {a[23:1], 1'b0}; ed[0] = wd; end
      else if (c[3]) begin
        em[0] = a[0] ? 2'b01 : 2'b10; ea[0] = a; ed[0] = {wd[7:0], wd[7:0]};
      end else if (!word) begin em[0] = 2'b01; ea[0] = a; ed[0] = {wd[7:0], wd[7:0]}; end
      else begin
        ne = 2;
        em[0] = 2'b01; ea[0] = {a[23:1], 1'b0}; ed[0] = {wd[15:8], wd[15:8]};
        em[1] = 2'b01; ea[1] = {a[23:1], 1'b1}; ed[1] = {wd[7:0], wd[7:0]};
      end
      chk(nev == ne, "R7 R8 write strobe count", nev, ne);
      for (int k = 0; k < ne && k < nev; k++) begin
        logic [15:0] lm = {{8{em[k][1]}}, {8{em[k][0]}}};
        chk(ev_m[k] == em[k] && ev_a[k] == ea[k] && (ev_d[k] & lm) == (ed[k] & lm),
            "R7 R8 write lane/address/data", {ev_m[k], ev_a[k]}, {em[k], ea[k]});
      end
    end
    @(negedge clk);
  endtask

  // cfg: rd_late, post, pre, wait_en, three, wide, waits
  function automatic logic [8:0] mk(bit rl, bit po, bit pr, bit we, bit th, bit wi, int w);
    return {rl, po, pr, we, th, wi, 3'(w)};
  endfunction

  initial begin
    void'($urandom(32'd20250601));
    for (int i = 0; i < 8; i++) bcfg[i] = '0;
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; req = 0; req_addr = 0;
    req_we = 0; req_word = 0; req_wdata = 0; ext_wait = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 8'hFF, "R1 chip selects idle after reset", cs_n, 8'hFF);
    chk(rd_n && wrh_n && wrl_n && !ack && !bus_oe, "R10 idle outputs after reset",
        {rd_n, wrh_n, wrl_n, ack, bus_oe}, 5'b11100);
    // R2: reset setup is 8-bit 2-state
    access(24'h0A0012, 0, 1, 16'h0, 0);
    access(24'h0A0013, 1, 1, 16'hBEEF, 0);

    set_cfg(1, mk(0, 0, 0, 1, 1, 1, 2));   // R4 R5
    access(24'h200100, 0, 1, 0, 0);
    access(24'h200102, 0, 1, 0, 7);
    set_cfg(2, mk(0, 0, 0, 1, 0, 1, 5));   // R3: waits ignored in 2-state
    access(24'h400021, 0, 0, 0, 9);
    set_cfg(3, mk(0, 0, 0, 0, 1, 0, 0));   // R5: enable clear ignores pin
    access(24'h600044, 0, 0, 0, 8);
    set_cfg(4, mk(1, 1, 1, 0, 0, 0, 0));   // R6 R8 R9
    access(24'h800010, 0, 1, 0, 0);
    set_cfg(5, mk(1, 0, 0, 0, 0, 1, 0));   // R9
    access(24'hA00055, 0, 0, 0, 0);
    access(24'hA00054, 0, 1, 0, 0);
    set_cfg(6, mk(0, 0, 0, 0, 1, 1, 1));   // R7 lanes
    access(24'hC00031, 1, 0, 16'h00A5, 0);
    access(24'hC00030, 1, 0, 16'h005A, 0);
    access(24'hC00030, 1, 1, 16'h1234, 0);
    set_cfg(7, mk(0, 1, 1, 1, 1, 0, 1));   // R5 R8 two phases
    access(24'hE00070, 1, 1, 16'hCAFE, 5);
    access(24'hE00070, 0, 1, 0, 11);

    for (int i = 0; i < 60; i++) begin
      if (i % 6 == 0) set_cfg(int'($urandom % 8), 9'($urandom));
      access(24'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), ($urandom % 3 == 0) ? int'($urandom % 12) : 0);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule